// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block drives one complete I2C message, read or write, on top of a byte-level bus controller. The requester gives a device address, a direction flag, a flag for 10-bit addressing and a byte count, then pulses a go strobe. The controller reports every bus event as an 8-bit status code. The sequencer answers each code with one command: it supplies an address or data byte, it sets or clears the acknowledge bit for the next received byte, or it requests a STOP. When the message ends, it pulses done together with an error code.

Outgoing bytes are read from a buffer that belongs to the requester. The sequencer presents the index of the next byte, and the buffer returns that byte one cycle later. Incoming bytes are written back through a single write strobe with its own index and data. The buffer can therefore be a synchronous block RAM. The controller must leave at least two cycles between status events.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, busy, done, cmd_valid and buf_we are all 0.
- R2: A go pulse while idle, with no status event in the same cycle, produces a command with cmd_start=1 and cmd_ack=1 in the next cycle. busy rises in the same cycle.
- R3: With 7-bit addressing, the status codes 0x08 (START) and 0x10 (repeated START) load the byte {addr[6:0], dir}, where dir=1 means read.
- R4: With 10-bit addressing, the first address byte is {5'b11110, addr[9:8], dir}. The address-ACK code (0x18 for a write, 0x40 for a read) then loads addr[7:0]. After that, 0xD0 (write) or 0xE0 (read) continues the message.
- R5: In a write, each ACK code (0x18, 0xD0 or 0x28) loads buffer byte i, where i counts from 0, if bytes remain. Once the count reaches zero, the next ACK issues a STOP with done=1 and err=0.
- R6: In a read, cmd_ack stays 1 until the remaining count equals 1 and is 0 from then on. Code 0x50 writes the received byte to buffer index i and continues. Code 0x58 writes the final byte, issues a STOP and ends the message with err=0.
- R7: Codes 0x20, 0x30 and 0x48 issue a STOP and end the message with err=1 (no device).
- R8: Any other code during a message issues a STOP with cmd_reset=1 and ends the message with err=2 (I/O error).
- R9: A status event while idle issues only a STOP. done stays 0 and busy stays 0.
- R10: A read with length 0 sends the address, then issues a STOP on the address ACK without loading any byte, and ends with err=0.
- R11: A go pulse while busy is ignored. It produces no command and does not change the address being sent.
- R12: done is high for exactly one cycle per message, and err is non-zero only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_go | input | 1 | Starts a message when idle |
| msg_addr | input | 10 | Device address (7- or 10-bit) |
| msg_read | input | 1 | 1 = read, 0 = write |
| msg_ten | input | 1 | 1 = 10-bit addressing |
| msg_len | input | LEN_W | Byte count |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| err | output | 2 | 0 ok, 1 no device, 2 I/O error (valid with done) |
| ev_valid | input | 1 | Status event strobe from the controller |
| ev_code | input | 8 | Status code |
| ev_rdata | input | 8 | Received byte, valid with ev_valid |
| cmd_valid | output | 1 | One-cycle command strobe to the controller |
| cmd_start | output | 1 | Request a START |
| cmd_stop | output | 1 | Request a STOP |
| cmd_ack | output | 1 | Acknowledge the next received byte |
| cmd_load | output | 1 | cmd_byte is to be transmitted |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_reset | output | 1 | Reset the controller |
| buf_raddr | output | LEN_W | Index of the next byte to send |
| buf_rdata | input | 8 | Buffer byte at buf_raddr (one-cycle latency allowed) |
| buf_we | output | 1 | Write a received byte |
| buf_waddr | output | LEN_W | Write index |
| buf_wdata | output | 8 | Received byte |

## Verification
A wrong state or count shows at the ports on the very next command after the status event that follows the error. It can appear as a byte loaded where a STOP was due, a STOP one byte early, or a wrong byte index. A corrupted acknowledge bit shows on cmd_ack in the read command before the last byte, so it appears one event before the final NACK. A lost return to idle shows as a missing done pulse, or as a following go pulse that produces no START command.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_ADR1, S_ADR2, S_WACK, S_RDAT} seq_state_t;
  typedef enum logic [1:0] {E_OK = 2'd0, E_NODEV = 2'd1, E_IO = 2'd2} seq_err_t;
  typedef enum logic [1:0] {B_NONE, B_A1, B_A2, B_BUF} byte_sel_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_WA_ACK  = 8'h18;
  localparam logic [7:0] ST_WA_NAK  = 8'h20;
  localparam logic [7:0] ST_WD_ACK  = 8'h28;
  localparam logic [7:0] ST_WD_NAK  = 8'h30;
  localparam logic [7:0] ST_RA_ACK  = 8'h40;
  localparam logic [7:0] ST_RA_NAK  = 8'h48;
  localparam logic [7:0] ST_RD_ACK  = 8'h50;
  localparam logic [7:0] ST_RD_NAK  = 8'h58;
  localparam logic [7:0] ST_WA2_ACK = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK = 8'hE0;

  typedef struct packed {
    logic      valid;
    logic      stop;
    logic      load;
    logic      reset;
    logic      store;
    logic      dec;
    logic      fin;
    logic      ackclr;
    byte_sel_t bsel;
    seq_err_t  err;
  } seq_act_t;
endpackage

// File: rtl/i2cseq_addr_fmt.sv
module i2cseq_addr_fmt (
  input  logic [9:0] addr,
  input  logic       rd,
  input  logic       ten,
  output logic [7:0] first_b,
  output logic [7:0] second_b
);
  always_comb begin
    if (ten) first_b = {5'b11110, addr[9:8], rd};
    else     first_b = {addr[6:0], rd};
    second_b = addr[7:0];
  end
endmodule

// File: rtl/i2cseq_decide.sv
module i2cseq_decide
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  seq_state_t       state,
  input  logic [7:0]       code,
  input  logic             ten,
  input  logic [LEN_W-1:0] left,
  output seq_state_t       nxt,
  output seq_act_t         act
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  always_comb begin
    act = '0;
    nxt = state;
    act.valid = 1'b1;
    if (state == S_IDLE) begin
      act.stop = 1'b1;
    end else begin
      case (code)
        ST_START, ST_RSTART: begin
          act.load = 1'b1; act.bsel = B_A1; nxt = S_ADR1;
        end
        ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
          if (code == ST_WA_ACK && ten) begin
            act.load = 1'b1; act.bsel = B_A2; nxt = S_ADR2;
          end else if (left == '0) begin
            act.stop = 1'b1; act.fin = 1'b1;
          end else begin
            act.load = 1'b1; act.bsel = B_BUF; act.dec = 1'b1; nxt = S_WACK;
          end
        end
        ST_RA_ACK, ST_RA2_ACK, ST_RD_ACK: begin
          if (code == ST_RA_ACK && ten) begin
            act.load = 1'b1; act.bsel = B_A2; nxt = S_ADR2;
          end else if (code != ST_RD_ACK && left == '0) begin
            act.stop = 1'b1; act.fin = 1'b1;
          end else begin
            nxt = S_RDAT;
            if (code == ST_RD_ACK) begin
              act.store = 1'b1; act.dec = 1'b1; act.ackclr = (left == TWO);
            end else begin
              act.ackclr = (left == ONE);
            end
          end
        end
        ST_RD_NAK: begin
          act.store = 1'b1; act.stop = 1'b1; act.fin = 1'b1;
        end
        ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
          act.stop = 1'b1; act.fin = 1'b1; act.err = E_NODEV;
        end
        default: begin
          act.stop = 1'b1; act.reset = 1'b1; act.fin = 1'b1; act.err = E_IO;
        end
      endcase
      if (act.fin) nxt = S_IDLE;
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_go,
  input  logic [9:0]       msg_addr,
  input  logic             msg_read,
  input  logic             msg_ten,
  input  logic [LEN_W-1:0] msg_len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  input  logic             ev_valid,
  input  logic [7:0]       ev_code,
  input  logic [7:0]       ev_rdata,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_ack,
  output logic             cmd_load,
  output logic [7:0]       cmd_byte,
  output logic             cmd_reset,
  output logic [LEN_W-1:0] buf_raddr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [LEN_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata
);
  seq_state_t       state_q, nxt;
  seq_act_t         act;
  logic [LEN_W-1:0] left_q, pos_q;
  logic [9:0]       addr_q;
  logic             rd_q, ten_q, ack_q;
  logic [7:0]       a1, a2, byte_sel;

  i2cseq_addr_fmt u_fmt (
    .addr(addr_q), .rd(rd_q), .ten(ten_q), .first_b(a1), .second_b(a2)
  );

  i2cseq_decide #(.LEN_W(LEN_W)) u_dec (
    .state(state_q), .code(ev_code), .ten(ten_q), .left(left_q),
    .nxt(nxt), .act(act)
  );

  always_comb begin
    case (act.bsel)
      B_A1:    byte_sel = a1;
      B_A2:    byte_sel = a2;
      B_BUF:   byte_sel = buf_rdata;
      default: byte_sel = 8'h00;
    endcase
  end

  assign busy      = (state_q != S_IDLE);
  assign buf_raddr = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      left_q <= '0; pos_q <= '0; addr_q <= '0;
      rd_q <= 1'b0; ten_q <= 1'b0; ack_q <= 1'b0;
      cmd_valid <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_ack <= 1'b0;
      cmd_load <= 1'b0; cmd_byte <= 8'h00; cmd_reset <= 1'b0;
      done <= 1'b0; err <= 2'd0;
      buf_we <= 1'b0; buf_waddr <= '0; buf_wdata <= 8'h00;
    end else begin
      cmd_valid <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0;
      cmd_load <= 1'b0; cmd_reset <= 1'b0;
      done <= 1'b0; err <= 2'd0; buf_we <= 1'b0;
      if (ev_valid) begin
        state_q   <= nxt;
        cmd_valid <= act.valid;
        cmd_stop  <= act.stop;
        cmd_load  <= act.load;
        cmd_reset <= act.reset;
        cmd_ack   <= ack_q & ~act.ackclr;
        if (act.ackclr) ack_q <= 1'b0;
        if (act.load) cmd_byte <= byte_sel;
        if (act.dec) begin
          left_q <= left_q - 1'b1;
          pos_q  <= pos_q + 1'b1;
        end
        if (act.store) begin
          buf_we <= 1'b1; buf_waddr <= pos_q; buf_wdata <= ev_rdata;
        end
        if (act.fin) begin
          done <= 1'b1; err <= act.err;
        end
      end else if (msg_go && state_q == S_IDLE) begin
        state_q <= S_START;
        left_q <= msg_len; pos_q <= '0;
        addr_q <= msg_addr; rd_q <= msg_read; ten_q <= msg_ten;
        ack_q <= 1'b1;
        cmd_valid <= 1'b1; cmd_start <= 1'b1; cmd_ack <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       msg_go,
  input logic       busy,
  input logic       done,
  input logic [1:0] err,
  input logic       ev_valid,
  input logic       cmd_valid,
  input logic       cmd_start,
  input logic       cmd_stop,
  input logic       cmd_reset,
  input logic       buf_we
);
  // R2
  go_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_go && !busy && !ev_valid) |=> (cmd_valid && cmd_start && busy));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (err != 2'd0) |-> done);
  // R8
  reset_stops_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |-> (cmd_stop && done && err == 2'd2));
  // R9
  idle_event_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !busy) |=> (cmd_stop && !done && !busy));
  // R6
  store_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> cmd_valid);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind i2c_txn_seq i2cseq_chk u_chk (
  .clk(clk), .rst(rst), .msg_go(msg_go), .busy(busy), .done(done), .err(err),
  .ev_valid(ev_valid), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
  .cmd_stop(cmd_stop), .cmd_reset(cmd_reset), .buf_we(buf_we)
);

// File: tb/tb_i2c_txn_seq.sv
module tb_i2c_txn_seq;
  localparam int LEN_W = 8;

  typedef struct packed {
    logic       rd;
    logic       ten;
    logic [9:0] addr;
    logic [7:0] len;
    logic [7:0] nack;   // 0 = address NACK, i+1 = NACK on data byte i, FF = none
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 10'h050, 8'd3, 8'hFF},
    '{1'b1, 1'b0, 10'h02A, 8'd4, 8'hFF},
    '{1'b1, 1'b0, 10'h011, 8'd1, 8'hFF},
    '{1'b0, 1'b1, 10'h2C5, 8'd2, 8'hFF},
    '{1'b1, 1'b1, 10'h1A3, 8'd2, 8'hFF},
    '{1'b0, 1'b0, 10'h022, 8'd3, 8'd2},
    '{1'b1, 1'b0, 10'h033, 8'd2, 8'd0},
    '{1'b1, 1'b0, 10'h044, 8'd0, 8'hFF},
    '{1'b0, 1'b0, 10'h05B, 8'd0, 8'hFF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic msg_go = 1'b0, msg_read = 1'b0, msg_ten = 1'b0;
  logic [9:0] msg_addr = '0;
  logic [LEN_W-1:0] msg_len = '0;
  logic ev_valid = 1'b0;
  logic [7:0] ev_code = '0, ev_rdata = '0;
  logic busy, done, cmd_valid, cmd_start, cmd_stop, cmd_ack, cmd_load, cmd_reset, buf_we;
  logic [1:0] err;
  logic [7:0] cmd_byte, buf_rdata, buf_wdata;
  logic [LEN_W-1:0] buf_raddr, buf_waddr;
  logic [7:0] txbuf [16];
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  assign buf_rdata = txbuf[buf_raddr[3:0]];

  i2c_txn_seq #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .msg_go(msg_go), .msg_addr(msg_addr), .msg_read(msg_read),
    .msg_ten(msg_ten), .msg_len(msg_len), .busy(busy), .done(done), .err(err),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_rdata(ev_rdata),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_ack(cmd_ack),
    .cmd_load(cmd_load), .cmd_byte(cmd_byte), .cmd_reset(cmd_reset),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ev(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk); ev_valid = 1'b1; ev_code = c; ev_rdata = d;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic go(input vec_t v);
    @(negedge clk);
    msg_go = 1'b1; msg_addr = v.addr; msg_read = v.rd; msg_ten = v.ten; msg_len = v.len;
    @(negedge clk); msg_go = 1'b0;
  endtask

  task automatic run_msg(input vec_t v);
    logic [7:0] a1;
    a1 = v.ten ? {5'b11110, v.addr[9:8], v.rd} : {v.addr[6:0], v.rd};
    go(v);
    chk("R2", "start cmd", {cmd_valid, cmd_start, cmd_stop, cmd_ack, busy}, 5'b11011);
    ev(8'h08, 8'h00);
    chk(v.ten ? "R4" : "R3", "first addr byte", {cmd_load, cmd_byte}, {1'b1, a1});
    if (v.ten) begin
      ev(v.rd ? 8'h40 : 8'h18, 8'h00);
      chk("R4", "second addr byte", {cmd_load, cmd_byte}, {1'b1, v.addr[7:0]});
    end
    if (v.nack == 8'd0) begin
      ev(v.rd ? 8'h48 : 8'h20, 8'h00);
      chk("R7", "addr nack", {cmd_stop, done, err}, {1'b1, 1'b1, 2'd1});
      return;
    end
    ev(v.ten ? (v.rd ? 8'hE0 : 8'hD0) : (v.rd ? 8'h40 : 8'h18), 8'h00);
    if (v.len == 8'd0) begin
      chk(v.rd ? "R10" : "R5", "zero length stop",
          {cmd_valid, cmd_stop, cmd_load, done, err}, {4'b1101, 2'd0});
      return;
    end
    if (!v.rd) begin
      for (int i = 0; i < int'(v.len); i++) begin
        chk("R5", "data byte", {cmd_load, cmd_stop, cmd_byte}, {2'b10, txbuf[i]});
        if (int'(v.nack) == i + 1) begin
          ev(8'h30, 8'h00);
          chk("R7", "data nack", {cmd_stop, done, err}, {1'b1, 1'b1, 2'd1});
          return;
        end
        ev(8'h28, 8'h00);
      end
      chk("R5", "write stop", {cmd_stop, cmd_load, done, err}, {3'b101, 2'd0});
    end else begin
      chk("R6", "first read cmd", {cmd_valid, cmd_load, cmd_stop, cmd_ack},
          {3'b100, v.len != 8'd1});
      for (int i = 0; i < int'(v.len) - 1; i++) begin
        ev(8'h50, 8'hA0 + 8'(i));
        chk("R6", "store byte", {buf_we, buf_waddr, buf_wdata, cmd_stop, cmd_ack},
            {1'b1, 8'(i), 8'hA0 + 8'(i), 1'b0, (int'(v.len) - 1 - i) != 1});
      end
      ev(8'h58, 8'hC5);
      chk("R6", "last byte stop", {buf_we, buf_waddr, buf_wdata, cmd_stop, done, err},
          {1'b1, 8'(v.len - 8'd1), 8'hC5, 2'b11, 2'd0});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    vec_t d;
    for (int i = 0; i < 16; i++) txbuf[i] = 8'h31 + 8'(i * 7);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs", {busy, done, cmd_valid, buf_we}, 0);

    for (int k = 0; k < NV; k++) begin
      run_msg(VEC[k]);
      @(negedge clk);
      chk("R12", "done one cycle", {done, busy, err}, 0);
    end

    // R9: status event while idle
    ev(8'h28, 8'h00);
    chk("R9", "idle event", {cmd_valid, cmd_stop, cmd_load, done, busy}, 5'b11000);

    // R8: unexpected code mid-message
    d = '{1'b0, 1'b0, 10'h015, 8'd2, 8'hFF};
    go(d);
    ev(8'h08, 8'h00);
    ev(8'hF8, 8'h00);
    chk("R8", "unexpected code", {cmd_stop, cmd_reset, done, err}, {3'b111, 2'd2});
    @(negedge clk);
    chk("R8", "idle after error", {busy, done}, 0);

    // R11: go while busy is ignored
    d = '{1'b0, 1'b0, 10'h010, 8'd1, 8'hFF};
    go(d);
    d.addr = 10'h07F;
    go(d);
    chk("R11", "no cmd from busy go", {cmd_valid, busy}, 2'b01);
    ev(8'h08, 8'h00);
    chk("R11", "addr unchanged", cmd_byte, 8'h20);
    ev(8'h20, 8'h00);
    chk("R7", "write addr nack", {done, err}, {1'b1, 2'd1});

    summary();
    $finish;
  end
endmodule